// File: doc/BRIEF.md
# Free-Running Timestamp Counter

This block keeps a wide free-running time base that only ever counts up. It advances by one on every clock cycle in which counting is enabled and the external tick-enable input is high. It has no reload value, no compare logic and no interrupt output. The full count also leaves the block as a direct output, so that nearby logic can sample it without going through the bus.

Software sees the count through two 32-bit registers on a simple single-cycle read/write port. The low word holds the bottom bits of the count. The high register holds the top bits in its lowest byte and the enable flag in bit 8. Reading the low word also captures the top bits, so a low-then-high read pair always returns a consistent value, even when the low word rolls over between the two accesses.

The widths are parameters, with a 32-bit low part and an 8-bit high part by default. Smaller instances can therefore reach their wrap point in a short run.

Top module: `tstamp40`

## Requirements
- R1: After reset the count is zero, counting is disabled, and a read of either register returns zero.
- R2: A write to offset 0x64 sets the enable flag from bit 8 of the write data (1 enables, 0 disables). The other data bits are ignored and the count is left unchanged.
- R3: The count increases by exactly one on each clock edge at which the enable flag is set and tick_en is high. At every other edge it holds its value.
- R4: After all ones, the count wraps to zero on the next counted tick. For the default widths this happens after 2^40 ticks.
- R5: A read at offset 0x60 returns the low LO_W bits of the current count in the same cycle, zero-extended.
- R6: A read at offset 0x60 captures the top HI_W bits of the count at that clock edge. A later read at offset 0x64 returns the captured bits in its lowest bits until the next low read.
- R7: A read at offset 0x64 returns the enable flag in bit 8 and zero in every other bit above the captured field.
- R8: A write to offset 0x60 has no effect on the count or on the captured bits.
- R9: count_out always carries the whole count, with the low part in the low bits, and a carry out of the low part increments the high part.
- R10: A read at any offset other than 0x60 or 0x64, and any write cycle, returns zero on bus_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count tick enable, one cycle per tick |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| count_out | output | LO_W+HI_W | Direct view of the count |

## Verification
The assertions rely on the bus being quiet while the internal reset release is still in progress. They also rely on every access lasting a single cycle, with bus_sel and bus_wr held steady from one clock edge to the next. The stimulus changes inputs only between edges, leaves at least three idle cycles after each reset, and issues accesses strictly one cycle at a time. Tick patterns cover dense runs, sparse pseudo-random runs and idle stretches. A narrow second instance reaches its carry and wrap points within the run.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_LO = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_HI = 8'h64;
  localparam int EN_BIT = 8;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_LO,
    ACC_RD_HI,
    ACC_WR_LO,
    ACC_WR_HI
  } tsc_acc_e;
endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/tsc_regif.sv
module tsc_regif
  import tsc_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output tsc_acc_e          acc
);
  always_comb begin
    acc = ACC_NONE;
    if (bus_sel) begin
      unique case (bus_addr)
        OFS_LO:  acc = bus_wr ? ACC_WR_LO : ACC_RD_LO;
        OFS_HI:  acc = bus_wr ? ACC_WR_HI : ACC_RD_HI;
        default: acc = ACC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tsc_core.sv
module tsc_core #(
  parameter int CW = 40
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          tick_en,
  input  logic          en_wr,
  input  logic          en_wval,
  output logic          en_q,
  output logic [CW-1:0] cnt_q
);
  logic          en_d;
  logic          cnt_ce;
  logic [CW-1:0] cnt_d;

  always_comb begin
    en_d   = en_wr ? en_wval : en_q;
    cnt_ce = en_q & tick_en;
    cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q <= 1'b0;
    end else if (en_wr) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tsc_snap.sv
module tsc_snap #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic            cap,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] snap_q
);
  logic [HI_W-1:0] snap_d;

  always_comb begin
    snap_d = hi_in;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      snap_q <= '0;
    end else if (cap) begin
      snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/tstamp40.sv
module tstamp40
  import tsc_pkg::*;
#(
  parameter int LO_W = 32,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [LO_W+HI_W-1:0] count_out
);
  localparam int CW = LO_W + HI_W;

  logic            rst_q;
  tsc_acc_e        acc;
  logic            en_q;
  logic [CW-1:0]   cnt_q;
  logic [HI_W-1:0] snap_q;

  tsc_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  tsc_regif u_regif (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .acc      (acc)
  );

  tsc_core #(.CW(CW)) u_core (
    .clk     (clk),
    .rst_q   (rst_q),
    .tick_en (tick_en),
    .en_wr   (acc == ACC_WR_HI),
    .en_wval (bus_wdata[EN_BIT]),
    .en_q    (en_q),
    .cnt_q   (cnt_q)
  );

  tsc_snap #(.HI_W(HI_W)) u_snap (
    .clk    (clk),
    .rst_q  (rst_q),
    .cap    (acc == ACC_RD_LO),
    .hi_in  (cnt_q[CW-1:LO_W]),
    .snap_q (snap_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (acc)
      ACC_RD_LO: bus_rdata[LO_W-1:0] = cnt_q[LO_W-1:0];
      ACC_RD_HI: begin
        bus_rdata[HI_W-1:0] = snap_q;
        bus_rdata[EN_BIT]   = en_q;
      end
      default:   bus_rdata = '0;
    endcase
  end

  assign count_out = cnt_q;
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int LO_W = 32,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst_q,
  input logic                 tick_en,
  input logic                 en_q,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [HI_W-1:0]      snap_q,
  input logic [LO_W+HI_W-1:0] count_out
);
  localparam int CW = LO_W + HI_W;

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (en_q && tick_en) |=> count_out == CW'($past(count_out) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    !(en_q && tick_en) |=> $stable(count_out));

  assert_enwr_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && bus_wr && bus_addr == 8'h64) |=> en_q == $past(bus_wdata[8]));

  assert_hizero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && !bus_wr && bus_addr == 8'h64) |-> bus_rdata[31:9] == '0);

  assert_snaphold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_sel && !bus_wr && bus_addr == 8'h60) |=> $stable(snap_q));

  assert_lowrd_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && !bus_wr && bus_addr == 8'h60) |-> bus_rdata[LO_W-1:0] == count_out[LO_W-1:0]);

  assert_wrzero_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && bus_wr) |-> bus_rdata == '0);
endmodule

bind tstamp40 tsc_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .tick_en   (tick_en),
  .en_q      (en_q),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .snap_q    (snap_q),
  .count_out (count_out)
);

// File: tb/tb_tstamp40.sv
module tb_tstamp40;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        sel;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd0;
  logic [31:0] rd1;
  logic [39:0] cnt0;
  logic [5:0]  cnt1;

  int n_chk;
  int n_fail;

  longint m_cnt  [2];
  longint m_snap [2];
  longint m_en   [2];
  int     m_lw   [2];
  int     m_hw   [2];

  tstamp40 dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd0), .count_out(cnt0)
  );

  tstamp40 #(.LO_W(4), .HI_W(2)) dut_s (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd1), .count_out(cnt1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint mask(input int w);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic longint exp_rd(input int i);
    if (!sel || wr) return 0;
    if (addr == 8'h60) return m_cnt[i] & mask(m_lw[i]);
    if (addr == 8'h64) return (m_en[i] << 8) | m_snap[i];
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_snap[i] = 0; m_en[i] = 0;
    end
  endtask

  // One bus cycle: drive, check before the edge, advance model at the edge.
  task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic t, input string tag);
    sel = s; wr = w; addr = a; wdata = d; tick = t;
    #1;
    check({tag, " count_out R9"}, longint'(cnt0), m_cnt[0]);
    check({tag, " count_out small R9"}, longint'(cnt1), m_cnt[1]);
    check({tag, " rdata"}, longint'(rd0), exp_rd(0));
    check({tag, " rdata small"}, longint'(rd1), exp_rd(1));
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      longint old_cnt;
      old_cnt = m_cnt[i];
      if (m_en[i] != 0 && t) m_cnt[i] = (old_cnt + 1) & mask(m_lw[i] + m_hw[i]);
      if (s && !w && a == 8'h60) m_snap[i] = (old_cnt >> m_lw[i]) & mask(m_hw[i]);
      if (s && w && a == 8'h64) m_en[i] = longint'(d[8]);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; wdata = 0; tick = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 8'h00, 0, 0, "R1 idle");
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_lw[0] = 32; m_hw[0] = 8; m_lw[1] = 4; m_hw[1] = 2;
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; wdata = 0; tick = 0;
    model_reset();
    do_reset();

    // R1: reset state seen through the bus and count_out
    check("R1 count zero", longint'(cnt0), 0);
    cyc(1, 0, 8'h60, 0, 1, "R1 low read");
    cyc(1, 0, 8'h64, 0, 1, "R1 high read");
    // R3: ticks while disabled hold the count
    repeat (5) cyc(0, 0, 8'h00, 0, 1, "R3 disabled tick");
    check("R3 held while disabled", longint'(cnt0), 0);

    // R2: enable with extra data bits set
    cyc(1, 1, 8'h64, 32'hFFFF_FFFF, 0, "R2 enable write");
    check("R2 count unchanged by write", longint'(cnt0), 0);
    cyc(1, 0, 8'h64, 0, 0, "R7 enable readback");
    // R3: dense ticks
    repeat (10) cyc(0, 0, 8'h00, 0, 1, "R3 dense");
    check("R3 ten ticks", longint'(cnt0), 10);
    // R3: sparse pseudo-random ticks
    for (int k = 0; k < 40; k++) cyc(0, 0, 8'h00, 0, 1'($urandom_range(0, 1)), "R3 sparse");

    // R5 and R6: coherent pair, then ticks between the reads
    cyc(1, 0, 8'h60, 0, 1, "R5 low read");
    repeat (20) cyc(0, 0, 8'h00, 0, 1, "R6 gap");
    cyc(1, 0, 8'h64, 0, 1, "R6 high read");
    // R8: low write ignored
    cyc(1, 1, 8'h60, 32'hFFFF_FFFF, 1, "R8 low write");
    cyc(1, 0, 8'h64, 0, 0, "R8 snap intact");
    // R10: unmapped read and misaligned read
    cyc(1, 0, 8'h68, 0, 1, "R10 unmapped");
    cyc(1, 0, 8'h61, 0, 1, "R10 misaligned");
    cyc(1, 1, 8'h64, 32'h0000_0100, 1, "R10 write rdata");

    // R2: disable with bit 8 clear, other bits set
    cyc(1, 1, 8'h64, 32'hFFFF_FEFF, 1, "R2 disable write");
    begin
      longint held;
      held = longint'(cnt0);
      repeat (6) cyc(0, 0, 8'h00, 0, 1, "R2 disabled");
      check("R2 held after disable", longint'(cnt0), held);
    end
    cyc(1, 0, 8'h64, 0, 0, "R7 disabled readback");

    // R4 and R9 on the narrow instance: carry at 16, wrap at 64
    do_reset();
    cyc(1, 1, 8'h64, 32'h0000_0100, 0, "R2 re-enable");
    repeat (16) cyc(0, 0, 8'h00, 0, 1, "R9 to carry");
    check("R9 carry into high part", longint'(cnt1), 16);
    cyc(1, 0, 8'h60, 0, 0, "R9 low read at carry");
    cyc(1, 0, 8'h64, 0, 0, "R9 high read at carry");
    repeat (47) cyc(0, 0, 8'h00, 0, 1, "R4 to top");
    check("R4 all ones", longint'(cnt1), 63);
    cyc(1, 0, 8'h60, 0, 1, "R4 low read at top");
    check("R4 wrapped to zero", longint'(cnt1), 0);
    check("R4 wide no wrap", longint'(cnt0), 64);
    cyc(1, 0, 8'h64, 0, 0, "R6 snap from top");
    repeat (5) cyc(0, 0, 8'h00, 0, 1, "R4 after wrap");

    // R1: reset in the middle of counting
    do_reset();
    check("R1 cleared after reset", longint'(cnt0), 0);
    cyc(1, 0, 8'h64, 0, 1, "R1 enable cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule